// File: doc/BRIEF.md
# Dual-Plane Pixel Colour Selector

This block builds one 32-bit display pixel per clock from three framebuffer planes that are read in lockstep. The planes are an 8-bit palette index, a 32-bit direct-colour word and a 32-bit control word. The top byte of the control word is a tag. One tag value selects the direct colour. Every other value sends the index to an external palette and uses the colour that comes back. The block packs the chosen colour in red-green-blue order or in blue-green-red order, as a static configuration bit directs.

Pixels enter and leave on a valid/ready stream. Internal raster counters follow the active width and height, which are configuration inputs of up to 1024 by 768. From these counters the block gives each output pixel an end-of-line marker, an end-of-frame marker and its element offset in the planes. That offset uses a line pitch of 1024 elements, whatever the active width is.

The palette RAM sits outside the block and is read synchronously. The block drives the read address and enable in the cycle a pixel is accepted, and it takes the returned colour in the following cycle.

Top module: `pixel_plane_sel`

## Requirements
- R1: When `in_ctrl[31:24]` equals 8'h03, the pixel takes its colour from `in_direct`. For any other value of that byte, including 8'h00, 8'h02 and 8'h83, the pixel takes its colour from the palette entry for `in_index`. Bits 23:0 of `in_ctrl` have no effect.
- R2: A direct-colour word carries red in bits 7:0, green in bits 15:8 and blue in bits 23:16. Bits 31:24 have no effect on the output.
- R3: `pal_rd_en` is high exactly when a pixel is accepted (`in_valid && in_ready`), with `pal_rd_addr` equal to `in_index`. The RAM returns `{red[23:16], green[15:8], blue[7:0]}` on `pal_rd_rgb` in the next cycle and holds that value while `pal_rd_en` is low.
- R4: With `cfg_bgr`=0, `out_pixel` is `{8'h00, red, green, blue}`. With `cfg_bgr`=1, it is `{8'h00, blue, green, red}`.
- R5: A pixel accepted at a clock edge is presented on the outputs, with `out_valid` high, immediately after that edge.
- R6: `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, every output holds. Pixels leave in arrival order, with none dropped or repeated.
- R7: `out_eol` is high on the pixel whose column equals `cfg_width`-1, and low on every other pixel.
- R8: `out_eof` is high only on the last pixel of row `cfg_height`-1. After that pixel the raster restarts at column 0 of row 0.
- R9: `out_addr` equals row*1024 + column, whatever the active width is.
- R10: During and after reset, `out_valid` is 0, `in_ready` is 1 and the raster position is column 0 of row 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_bgr | input | 1 | Output packing: 0 = RGB, 1 = BGR |
| cfg_width | input | 11 | Active pixels per line (1..1024) |
| cfg_height | input | 10 | Active lines per frame (1..768) |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_index | input | 8 | Indexed-plane byte |
| in_direct | input | 32 | Direct-colour plane word |
| in_ctrl | input | 32 | Control-plane word (tag in bits 31:24) |
| pal_rd_en | output | 1 | Palette read strobe |
| pal_rd_addr | output | 8 | Palette read address |
| pal_rd_rgb | input | 24 | Palette data, valid the cycle after the strobe |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream can take the pixel |
| out_pixel | output | 32 | Packed colour |
| out_eol | output | 1 | Last active pixel of a line |
| out_eof | output | 1 | Last pixel of a frame |
| out_addr | output | 20 | Plane element offset of the pixel |

## Verification
Each accepted pixel appears on the outputs one cycle after the edge that accepts it, and its palette colour arrives in that same cycle. Inputs are driven on the falling edge. One nanosecond later the bench decides which handshakes the next rising edge will complete. `out_valid` is checked in the cycle after each accept. Output pixel k is compared with values computed arithmetically from k when it is consumed, so a pixel that stays stalled is compared only once. Sweeps over several widths, heights, tag values and valid/ready gaps cover line wrap, frame wrap, the 1024-pixel line and the single-pixel frame.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    localparam logic [7:0] DIRECT_TAG = 8'h03;

    typedef struct packed {
        logic [7:0] red;
        logic [7:0] green;
        logic [7:0] blue;
    } rgb_t;

    function automatic logic tag_is_direct(input logic [31:0] ctrl_word);
        return ctrl_word[31:24] == DIRECT_TAG;
    endfunction

    function automatic rgb_t unpack_direct(input logic [31:0] word);
        rgb_t c;
        c.blue  = word[23:16];
        c.green = word[15:8];
        c.red   = word[7:0];
        return c;
    endfunction

    function automatic logic [31:0] pack_pixel(input rgb_t c, input logic bgr);
        return bgr ? {8'h00, c.blue, c.green, c.red}
                   : {8'h00, c.red, c.green, c.blue};
    endfunction

endpackage

// File: rtl/dpc_raster_pos.sv
module dpc_raster_pos #(
    parameter int MAX_W = 1024,
    parameter int MAX_H = 768,
    localparam int XW  = $clog2(MAX_W),
    localparam int YW  = $clog2(MAX_H),
    localparam int WCW = $clog2(MAX_W + 1),
    localparam int HCW = $clog2(MAX_H + 1)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           step,
    input  logic [WCW-1:0] cfg_width,
    input  logic [HCW-1:0] cfg_height,
    output logic [XW-1:0]  col,
    output logic [YW-1:0]  row,
    output logic           last_col,
    output logic           last_row
);

    assign last_col = (WCW'(col) == cfg_width  - WCW'(1));
    assign last_row = (HCW'(row) == cfg_height - HCW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            col <= '0;
            row <= '0;
        end else if (step) begin
            if (last_col) begin
                col <= '0;
                row <= last_row ? '0 : row + YW'(1);
            end else begin
                col <= col + XW'(1);
            end
        end
    end

endmodule

// File: rtl/dpc_plane_decode.sv
module dpc_plane_decode
    import dpc_pkg::*;
(
    input  logic [31:0] ctrl_word,
    input  logic [31:0] direct_word,
    output logic        use_direct,
    output rgb_t        direct_rgb
);

    always_comb begin
        use_direct = tag_is_direct(ctrl_word);
        direct_rgb = unpack_direct(direct_word);
    end

endmodule

// File: rtl/dpc_pipe_reg.sv
module dpc_pipe_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          up_valid,
    output logic          up_ready,
    input  logic [DW-1:0] up_data,
    output logic          dn_valid,
    input  logic          dn_ready,
    output logic [DW-1:0] dn_data
);

    assign up_ready = !dn_valid || dn_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            dn_valid <= 1'b0;
            dn_data  <= '0;
        end else if (up_ready) begin
            dn_valid <= up_valid;
            if (up_valid) begin
                dn_data <= up_data;
            end
        end
    end

endmodule

// File: rtl/pixel_plane_sel.sv
module pixel_plane_sel
    import dpc_pkg::*;
#(
    parameter int MAX_W       = 1024,
    parameter int MAX_H       = 768,
    parameter int LINE_STRIDE = 1024,
    localparam int XW  = $clog2(MAX_W),
    localparam int YW  = $clog2(MAX_H),
    localparam int WCW = $clog2(MAX_W + 1),
    localparam int HCW = $clog2(MAX_H + 1),
    localparam int SW  = $clog2(LINE_STRIDE),
    localparam int AW  = YW + SW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_bgr,
    input  logic [WCW-1:0] cfg_width,
    input  logic [HCW-1:0] cfg_height,
    input  logic           in_valid,
    output logic           in_ready,
    input  logic [7:0]     in_index,
    input  logic [31:0]    in_direct,
    input  logic [31:0]    in_ctrl,
    output logic           pal_rd_en,
    output logic [7:0]     pal_rd_addr,
    input  logic [23:0]    pal_rd_rgb,
    output logic           out_valid,
    input  logic           out_ready,
    output logic [31:0]    out_pixel,
    output logic           out_eol,
    output logic           out_eof,
    output logic [AW-1:0]  out_addr
);

    typedef struct packed {
        logic          use_direct;
        rgb_t          direct_rgb;
        logic          eol;
        logic          eof;
        logic [AW-1:0] addr;
    } stage_t;

    localparam int STW = $bits(stage_t);

    logic          accept;
    logic [XW-1:0] col;
    logic [YW-1:0] row;
    logic          last_col;
    logic          last_row;
    logic          dec_direct;
    rgb_t          dec_rgb;
    logic [AW-1:0] elem_addr;
    stage_t        st_in;
    stage_t        st_out;
    logic [STW-1:0] st_out_bits;
    rgb_t          chosen;

    assign accept      = in_valid && in_ready;
    assign pal_rd_en   = accept;
    assign pal_rd_addr = in_index;

    dpc_raster_pos #(
        .MAX_W (MAX_W),
        .MAX_H (MAX_H)
    ) pos_i (
        .clk        (clk),
        .rst        (rst),
        .step       (accept),
        .cfg_width  (cfg_width),
        .cfg_height (cfg_height),
        .col        (col),
        .row        (row),
        .last_col   (last_col),
        .last_row   (last_row)
    );

    dpc_plane_decode dec_i (
        .ctrl_word   (in_ctrl),
        .direct_word (in_direct),
        .use_direct  (dec_direct),
        .direct_rgb  (dec_rgb)
    );

    generate
        if ((LINE_STRIDE & (LINE_STRIDE - 1)) == 0) begin : g_pow2_pitch
            assign elem_addr = {row, SW'(col)};
        end else begin : g_mul_pitch
            assign elem_addr = AW'(row) * AW'(LINE_STRIDE) + AW'(col);
        end
    endgenerate

    always_comb begin
        st_in.use_direct = dec_direct;
        st_in.direct_rgb = dec_rgb;
        st_in.eol        = last_col;
        st_in.eof        = last_col && last_row;
        st_in.addr       = elem_addr;
    end

    dpc_pipe_reg #(
        .DW (STW)
    ) stage_i (
        .clk      (clk),
        .rst      (rst),
        .up_valid (in_valid),
        .up_ready (in_ready),
        .up_data  (st_in),
        .dn_valid (out_valid),
        .dn_ready (out_ready),
        .dn_data  (st_out_bits)
    );

    assign st_out = stage_t'(st_out_bits);

    always_comb begin
        chosen    = st_out.use_direct ? st_out.direct_rgb : rgb_t'(pal_rd_rgb);
        out_pixel = pack_pixel(chosen, cfg_bgr);
        out_eol   = st_out.eol;
        out_eof   = st_out.eof;
        out_addr  = st_out.addr;
    end

endmodule

// File: rtl/dpc_checker.sv
module dpc_checker #(
    parameter int AW  = 20,
    parameter int SW  = 10,
    parameter int WCW = 11
) (
    input logic           clk,
    input logic           rst,
    input logic [WCW-1:0] cfg_width,
    input logic           in_valid,
    input logic           in_ready,
    input logic           pal_rd_en,
    input logic           out_valid,
    input logic           out_ready,
    input logic [31:0]    out_pixel,
    input logic           out_eol,
    input logic           out_eof,
    input logic [AW-1:0]  out_addr
);

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_pixel)
            && $stable(out_addr) && $stable(out_eol) && $stable(out_eof));

    p_ready_rule_r6: assert property (@(posedge clk) disable iff (rst)
        !in_ready |-> out_valid && !out_ready);

    p_read_on_accept_r3: assert property (@(posedge clk) disable iff (rst)
        pal_rd_en |-> in_valid && in_ready);

    p_load_next_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |=> out_valid);

    p_pad_byte_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> out_pixel[31:24] == 8'h00);

    p_eof_has_eol_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_eof |-> out_eol);

    p_eol_column_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_eol |-> WCW'(out_addr[SW-1:0]) == cfg_width - WCW'(1));

    p_column_bound_r9: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> WCW'(out_addr[SW-1:0]) < cfg_width);

endmodule

bind pixel_plane_sel dpc_checker #(
    .AW  (AW),
    .SW  (SW),
    .WCW (WCW)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .cfg_width (cfg_width),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .pal_rd_en (pal_rd_en),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pixel (out_pixel),
    .out_eol   (out_eol),
    .out_eof   (out_eof),
    .out_addr  (out_addr)
);

// File: tb/pixel_plane_sel_tb_top.sv
`timescale 1ns/1ps
module pixel_plane_sel_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_bgr = 1'b0;
    logic [10:0] cfg_width = 11'd5;
    logic [9:0]  cfg_height = 10'd3;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_index = '0;
    logic [31:0] in_direct = '0;
    logic [31:0] in_ctrl = '0;
    logic        pal_rd_en;
    logic [7:0]  pal_rd_addr;
    logic [23:0] pal_q = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_pixel;
    logic        out_eol;
    logic        out_eof;
    logic [19:0] out_addr;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pixel_plane_sel dut_i (
        .clk         (clk),
        .rst         (rst),
        .cfg_bgr     (cfg_bgr),
        .cfg_width   (cfg_width),
        .cfg_height  (cfg_height),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_index    (in_index),
        .in_direct   (in_direct),
        .in_ctrl     (in_ctrl),
        .pal_rd_en   (pal_rd_en),
        .pal_rd_addr (pal_rd_addr),
        .pal_rd_rgb  (pal_q),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_pixel   (out_pixel),
        .out_eol     (out_eol),
        .out_eof     (out_eof),
        .out_addr    (out_addr)
    );

    function automatic logic [23:0] pal_of(input logic [7:0] i);
        return {i, i ^ 8'h5A, 8'(i * 3 + 17)};
    endfunction

    always @(posedge clk) begin
        if (pal_rd_en) pal_q <= pal_of(pal_rd_addr);
    end

    function automatic logic [7:0] idx_of(input int n);
        return 8'(n * 37 + 11);
    endfunction

    function automatic logic [31:0] dir_of(input int n);
        return {8'(n * 29 + 165), 8'(n * 7 + 1), 8'(n * 3 + 200), 8'(n * 5 + 4)};
    endfunction

    function automatic logic [31:0] ctrl_of(input int n);
        logic [23:0] junk;
        junk = 24'(n * 977);
        case (n % 5)
            0: return {8'h03, junk};
            1: return {8'h00, junk};
            2: return {8'h83, junk};
            3: return {8'h03, 24'hFFFFFF};
            default: return {8'h02, junk};
        endcase
    endfunction

    function automatic logic [31:0] exp_pixel(input int n, input logic bgr);
        logic [7:0] r, g, b;
        logic [31:0] d;
        logic [23:0] p;
        d = dir_of(n);
        p = pal_of(idx_of(n));
        if (ctrl_of(n)[31:24] == 8'h03) begin
            r = d[7:0]; g = d[15:8]; b = d[23:16];
        end else begin
            r = p[23:16]; g = p[15:8]; b = p[7:0];
        end
        return bgr ? {8'h00, b, g, r} : {8'h00, r, g, b};
    endfunction

    function automatic logic gate(input int pat, input int cyc);
        case (pat)
            0: return 1'b1;
            1: return (cyc % 3) != 2;
            2: return ((cyc * 7) % 5) < 2;
            default: return (cyc % 4) == 0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_phase(input int w, input int h, input logic bgr,
                             input int frames, input int vpat, input int rpat);
        int total, n, k, cyc, col, row;
        logic load_seen;
        total = w * h * frames;
        n = 0; k = 0; cyc = 0; load_seen = 1'b0;
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
        cfg_width = 11'(w); cfg_height = 10'(h); cfg_bgr = bgr;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10 reset out_valid", 32'(out_valid), 32'd0);
        check("R10 reset in_ready", 32'(in_ready), 32'd1);
        while (k < total) begin
            @(negedge clk);
            in_valid  = (n < total) && gate(vpat, cyc);
            in_index  = idx_of(n);
            in_direct = dir_of(n);
            in_ctrl   = ctrl_of(n);
            out_ready = gate(rpat, cyc + 1);
            #1;
            if (load_seen) check("R5 valid after accept", 32'(out_valid), 32'd1);
            if (out_valid && out_ready) begin
                col = k % w;
                row = (k / w) % h;
                check("R1 R2 R3 R4 pixel", out_pixel, exp_pixel(k, bgr));
                check("R7 R8 markers", {30'd0, out_eol, out_eof},
                      {30'd0, col == w - 1, (col == w - 1) && (row == h - 1)});
                check("R9 address", 32'(out_addr), 32'(row * 1024 + col));
                k++;
            end
            load_seen = in_valid && in_ready;
            if (load_seen) n++;
            cyc++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check("R6 accepted count", 32'(n), 32'(total));
        check("R6 no extra output", 32'(out_valid), 32'd0);
    endtask

    initial begin
        run_phase(5, 3, 1'b0, 2, 1, 2);
        run_phase(7, 2, 1'b1, 1, 2, 1);
        run_phase(1024, 2, 1'b0, 1, 0, 0);
        run_phase(1, 1, 1'b1, 4, 0, 2);
        run_phase(2, 768, 1'b1, 1, 0, 3);
        run_phase(3, 2, 1'b0, 2, 3, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule